// File: doc/BRIEF.md
# Analog Watchdog Window Monitor

This block sits beside a converter sequencer and checks every finished conversion result against a programmable window. A low and a high bound, each 12 bits wide, define the window. A result that falls strictly outside it sets a sticky excursion flag. An interrupt output follows that flag when interrupts are enabled. The comparison runs on the raw converter code, before any left or right justification is applied, so the bounds are always given as right-justified 12-bit codes.

Monitoring can be switched on separately for results of the regular group and for results of the injected group. A mode bit limits the check to a single watched channel, and that channel applies to both groups. With the mode bit clear, every eligible result is checked. Configuration is taken as a whole on a write strobe. The flag is cleared through a dedicated clear input, which stands for software writing zero to the flag.

Top module: `awd_window_monitor`

## Requirements
- R1: After reset, `awd_flag` and `awd_irq` are 0, both group enables, the single-channel mode bit and the interrupt enable are 0, and the watched channel is 0. With this configuration no result ever sets the flag.
- R2: On a configuration write, only bits 11:0 of `cfg_hi` and `cfg_lo` are kept and bits 15:12 are discarded. For example, writing 0xF800 as the high bound gives an effective bound of 0x800.
- R3: An eligible result sets the flag when its 12-bit value is strictly greater than the high bound or strictly less than the low bound. A value equal to either bound does not set it.
- R4: A result with `res_inj`=0 (regular group) is checked only while the regular enable is 1. A result with `res_inj`=1 (injected group) is checked only while the injected enable is 1. With both enables at 0, the flag is never set.
- R5: With the single-channel mode bit at 1, only results whose `res_chan` equals the watched channel are checked, for both groups. With the mode bit at 0, results on every channel are checked.
- R6: A configuration write whose `cfg_chan` is above MAX_CHAN (default 17) stores channel 0. A value of MAX_CHAN or below is stored as written.
- R7: The flag stays set until `flag_clr` is 1 at a clock edge. If a new excursion arrives in the same cycle as the clear, the flag stays set.
- R8: `awd_irq` equals `awd_flag` AND the interrupt enable. Both are registered on the same edge, so enabling interrupts while the flag is set raises `awd_irq` on the edge of the configuration write.
- R9: A cycle with `res_vld`=0 never sets the flag, whatever the data, channel and group inputs carry.
- R10: The flag reflects a result on the clock edge that samples `res_vld`=1. A configuration write applies to results presented from the next edge onward.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Load all configuration fields this cycle |
| cfg_reg_en | input | 1 | Enable checking of regular-group results |
| cfg_inj_en | input | 1 | Enable checking of injected-group results |
| cfg_single | input | 1 | 1: check only the watched channel; 0: check all channels |
| cfg_chan | input | 5 | Watched channel number |
| cfg_hi | input | 16 | High bound; upper 4 bits discarded |
| cfg_lo | input | 16 | Low bound; upper 4 bits discarded |
| cfg_irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Clear the excursion flag |
| res_vld | input | 1 | Conversion result strobe |
| res_data | input | 12 | Raw (unjustified) conversion code |
| res_chan | input | 5 | Channel the result came from |
| res_inj | input | 1 | 1: injected group, 0: regular group |
| awd_flag | output | 1 | Sticky out-of-window flag |
| awd_irq | output | 1 | Interrupt request |

## Verification
The bench places results exactly on each bound and one code beyond it. A design that uses inclusive comparisons, or that swaps the bounds, flags the wrong one of these. A high bound is written with its top nibble set, so a design that keeps those bits never sees the excursion. The bench steers results of each group into a configuration where only the other group is enabled, and runs single-channel mode with a watched channel above the limit, which must collapse to channel 0. It also drives a clear and a fresh excursion in the same cycle, where a design with the wrong priority drops the flag. Strobe-low cycles carry out-of-window data, which must leave the flag alone.

// File: rtl/awd_pkg.sv
package awd_pkg;

  // Group tag of a conversion result
  typedef enum logic {
    GRP_REGULAR  = 1'b0,
    GRP_INJECTED = 1'b1
  } awd_grp_e;

  // Mode bits held by the configuration bank
  typedef struct packed {
    logic reg_en;
    logic inj_en;
    logic single;
    logic irq_en;
  } awd_mode_t;

endpackage

// File: rtl/awd_cfg_bank.sv
module awd_cfg_bank
  import awd_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CFG_W    = 16,
  parameter int CHAN_W   = 5,
  parameter int MAX_CHAN = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic              reg_en,
  input  logic              inj_en,
  input  logic              single,
  input  logic              irq_en,
  input  logic [CHAN_W-1:0] chan,
  input  logic [CFG_W-1:0]  hi,
  input  logic [CFG_W-1:0]  lo,
  output awd_mode_t         mode_q,
  output logic [CHAN_W-1:0] chan_q,
  output logic [DATA_W-1:0] hi_q,
  output logic [DATA_W-1:0] lo_q
);

  localparam logic [CHAN_W-1:0] CHAN_LIMIT = CHAN_W'(MAX_CHAN);

  logic [CHAN_W-1:0] chan_legal;

  // Out-of-range channel numbers collapse to channel zero
  assign chan_legal = (chan > CHAN_LIMIT) ? '0 : chan;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= '0;
      chan_q <= '0;
      hi_q   <= '0;
      lo_q   <= '0;
    end else if (wr) begin
      mode_q <= '{reg_en: reg_en, inj_en: inj_en, single: single, irq_en: irq_en};
      chan_q <= chan_legal;
      hi_q   <= hi[DATA_W-1:0];
      lo_q   <= lo[DATA_W-1:0];
    end
  end

endmodule

// File: rtl/awd_window_cmp.sv
module awd_window_cmp
  import awd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CHAN_W = 5
) (
  input  logic              vld,
  input  logic [DATA_W-1:0] data,
  input  logic [CHAN_W-1:0] chan,
  input  awd_grp_e          grp,
  input  awd_mode_t         mode,
  input  logic [CHAN_W-1:0] chan_sel,
  input  logic [DATA_W-1:0] hi,
  input  logic [DATA_W-1:0] lo,
  output logic              excursion
);

  logic grp_ok;
  logic chan_ok;
  logic outside;

  always_comb begin
    unique case (grp)
      GRP_INJECTED: grp_ok = mode.inj_en;
      default:      grp_ok = mode.reg_en;
    endcase
    chan_ok   = !mode.single || (chan == chan_sel);
    outside   = (data > hi) || (data < lo);
    excursion = vld && grp_ok && chan_ok && outside;
  end

endmodule

// File: rtl/awd_flag_unit.sv
module awd_flag_unit (
  input  logic clk,
  input  logic rst,
  input  logic excursion,
  input  logic clr,
  input  logic irq_en_next,
  output logic flag_q,
  output logic irq_q
);

  logic flag_d;

  // A new excursion outranks a clear in the same cycle
  assign flag_d = excursion ? 1'b1 : (clr ? 1'b0 : flag_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= flag_d & irq_en_next;
    end
  end

endmodule

// File: rtl/awd_window_monitor.sv
module awd_window_monitor
  import awd_pkg::*;
#(
  parameter int DATA_W   = 12,
  parameter int CFG_W    = 16,
  parameter int CHAN_W   = 5,
  parameter int MAX_CHAN = 17
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_reg_en,
  input  logic              cfg_inj_en,
  input  logic              cfg_single,
  input  logic [CHAN_W-1:0] cfg_chan,
  input  logic [CFG_W-1:0]  cfg_hi,
  input  logic [CFG_W-1:0]  cfg_lo,
  input  logic              cfg_irq_en,
  input  logic              flag_clr,
  input  logic              res_vld,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CHAN_W-1:0] res_chan,
  input  logic              res_inj,
  output logic              awd_flag,
  output logic              awd_irq
);

  awd_mode_t         mode_q;
  logic [CHAN_W-1:0] chan_q;
  logic [DATA_W-1:0] hi_q;
  logic [DATA_W-1:0] lo_q;
  logic              excursion;
  logic              irq_en_next;
  awd_grp_e          grp;

  assign grp         = res_inj ? GRP_INJECTED : GRP_REGULAR;
  assign irq_en_next = cfg_wr ? cfg_irq_en : mode_q.irq_en;

  awd_cfg_bank #(
    .DATA_W(DATA_W), .CFG_W(CFG_W), .CHAN_W(CHAN_W), .MAX_CHAN(MAX_CHAN)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr),
    .reg_en(cfg_reg_en), .inj_en(cfg_inj_en), .single(cfg_single),
    .irq_en(cfg_irq_en), .chan(cfg_chan), .hi(cfg_hi), .lo(cfg_lo),
    .mode_q(mode_q), .chan_q(chan_q), .hi_q(hi_q), .lo_q(lo_q)
  );

  awd_window_cmp #(
    .DATA_W(DATA_W), .CHAN_W(CHAN_W)
  ) u_cmp (
    .vld(res_vld), .data(res_data), .chan(res_chan), .grp(grp),
    .mode(mode_q), .chan_sel(chan_q), .hi(hi_q), .lo(lo_q),
    .excursion(excursion)
  );

  awd_flag_unit u_flag (
    .clk(clk), .rst(rst), .excursion(excursion), .clr(flag_clr),
    .irq_en_next(irq_en_next), .flag_q(awd_flag), .irq_q(awd_irq)
  );

endmodule

// File: rtl/awd_window_monitor_chk.sv
module awd_window_monitor_chk (
  input logic clk,
  input logic rst,
  input logic cfg_wr,
  input logic cfg_irq_en,
  input logic flag_clr,
  input logic res_vld,
  input logic awd_flag,
  input logic awd_irq
);

  logic rst_seen;

  always_ff @(posedge clk) rst_seen <= rst;

  // R1: the cycle after a reset edge shows both outputs low
  always @(negedge clk) begin
    if (rst_seen === 1'b1) begin
      assert_reset_quiet_R1: assert (!awd_flag && !awd_irq)
        else $error("outputs not cleared by reset");
    end
  end

  // R7: the flag holds while no clear arrives
  assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    awd_flag && !flag_clr |=> awd_flag);

  // R9: without a strobe the flag cannot rise
  assert_no_set_without_vld_R9: assert property (@(posedge clk) disable iff (rst)
    !res_vld && !awd_flag |=> !awd_flag);

  // R7: a clear with no result drops the flag
  assert_clear_drops_R7: assert property (@(posedge clk) disable iff (rst)
    flag_clr && !res_vld |=> !awd_flag);

  // R8: interrupt never without the flag
  assert_irq_needs_flag_R8: assert property (@(posedge clk) disable iff (rst)
    awd_irq |-> awd_flag);

  // R8: disabling the interrupt silences it on the write edge
  assert_irq_off_R8: assert property (@(posedge clk) disable iff (rst)
    cfg_wr && !cfg_irq_en |=> !awd_irq);

endmodule

bind awd_window_monitor awd_window_monitor_chk u_chk (.*);

// File: tb/awd_window_monitor_test.sv
module awd_window_monitor_test;

  localparam int CLK_PERIOD = 10;
  localparam int MAX_CHAN   = 17;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_reg_en = 1'b0;
  logic        cfg_inj_en = 1'b0;
  logic        cfg_single = 1'b0;
  logic [4:0]  cfg_chan = '0;
  logic [15:0] cfg_hi = '0;
  logic [15:0] cfg_lo = '0;
  logic        cfg_irq_en = 1'b0;
  logic        flag_clr = 1'b0;
  logic        res_vld = 1'b0;
  logic [11:0] res_data = '0;
  logic [4:0]  res_chan = '0;
  logic        res_inj = 1'b0;
  logic        awd_flag;
  logic        awd_irq;

  int checks = 0;
  int errors = 0;

  typedef struct {
    logic  flag;
    logic  irq;
    string tag;
  } exp_t;

  exp_t sb[$];

  // Bench-side model of the configuration and flag
  logic        m_reg = 0, m_inj = 0, m_single = 0, m_ie = 0, m_flag = 0;
  logic [4:0]  m_chan = 0;
  logic [11:0] m_hi = 0, m_lo = 0;

  awd_window_monitor uut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_reg_en(cfg_reg_en),
    .cfg_inj_en(cfg_inj_en), .cfg_single(cfg_single), .cfg_chan(cfg_chan),
    .cfg_hi(cfg_hi), .cfg_lo(cfg_lo), .cfg_irq_en(cfg_irq_en),
    .flag_clr(flag_clr), .res_vld(res_vld), .res_data(res_data),
    .res_chan(res_chan), .res_inj(res_inj), .awd_flag(awd_flag), .awd_irq(awd_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic check(input string tag, input logic act_f, input logic act_i,
                       input logic exp_f, input logic exp_i);
    checks++;
    if (act_f !== exp_f || act_i !== exp_i) begin
      errors++;
      $display("FAIL %s flag/irq actual %b/%b expected %b/%b", tag, act_f, act_i, exp_f, exp_i);
    end
  endtask

  // Configuration write cycle, no result
  task automatic do_cfg(input logic reg_en, input logic inj_en, input logic single,
                        input logic [4:0] chan, input logic [15:0] hi,
                        input logic [15:0] lo, input logic ie, input string tag);
    exp_t e;
    @(negedge clk);
    cfg_wr = 1; cfg_reg_en = reg_en; cfg_inj_en = inj_en; cfg_single = single;
    cfg_chan = chan; cfg_hi = hi; cfg_lo = lo; cfg_irq_en = ie;
    res_vld = 0; flag_clr = 0;
    m_reg = reg_en; m_inj = inj_en; m_single = single; m_ie = ie;
    m_chan = (chan > 5'(MAX_CHAN)) ? 5'd0 : chan;   // R6
    m_hi = hi[11:0]; m_lo = lo[11:0];               // R2
    e.flag = m_flag; e.irq = m_flag & m_ie; e.tag = tag;
    sb.push_back(e);
  endtask

  // Result / clear cycle
  task automatic do_res(input logic vld, input logic [11:0] data, input logic [4:0] chan,
                        input logic inj, input logic clr, input string tag);
    exp_t e;
    logic hit;
    @(negedge clk);
    cfg_wr = 0; res_vld = vld; res_data = data; res_chan = chan; res_inj = inj;
    flag_clr = clr;
    hit = vld && (inj ? m_inj : m_reg) && (!m_single || chan == m_chan)
          && (data > m_hi || data < m_lo);
    m_flag = hit ? 1'b1 : (clr ? 1'b0 : m_flag);
    e.flag = m_flag; e.irq = m_flag & m_ie; e.tag = tag;
    sb.push_back(e);
  endtask

  // Scoreboard monitor: each item is due just after the next clock edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (sb.size() > 0) begin
        exp_t e;
        e = sb.pop_front();
        check(e.tag, awd_flag, awd_irq, e.flag, e.irq);
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset state", awd_flag, awd_irq, 1'b0, 1'b0);

    // R1/R4: default configuration never flags
    do_res(1, 12'hFFF, 5'd0, 0, 0, "R1 default config quiet");
    do_res(1, 12'hFFF, 5'd3, 1, 0, "R4 neither group enabled");

    // R2: upper nibble of bounds discarded; effective hi 0x800, lo 0x100
    do_cfg(1, 0, 0, 5'd0, 16'hF800, 16'hA100, 0, "R10 cfg write");
    do_res(1, 12'h800, 5'd2, 0, 0, "R3 equal high bound");
    do_res(1, 12'h801, 5'd2, 0, 0, "R2 masked high bound exceeded");
    do_cfg(1, 0, 0, 5'd0, 16'hF800, 16'hA100, 1, "R8 irq enable while flagged");
    do_res(0, 12'h000, 5'd0, 0, 1, "R7 clear");
    do_res(1, 12'h100, 5'd1, 0, 0, "R3 equal low bound");
    do_res(1, 12'h0FF, 5'd1, 0, 0, "R3 below low bound");
    do_res(1, 12'h400, 5'd1, 0, 0, "R7 flag sticky");
    do_res(1, 12'h0FF, 5'd1, 0, 1, "R7 set wins over clear");
    do_res(0, 12'h400, 5'd1, 0, 1, "R7 clear again");
    do_res(0, 12'h000, 5'd1, 0, 0, "R9 strobe low ignored");
    do_res(0, 12'hFFF, 5'd1, 0, 0, "R9 strobe low high data");

    // R4: group enables
    do_res(1, 12'hFFF, 5'd1, 1, 0, "R4 injected not enabled");
    do_cfg(0, 1, 0, 5'd0, 16'h0800, 16'h0100, 1, "R10 cfg injected only");
    do_res(1, 12'hFFF, 5'd1, 0, 0, "R4 regular not enabled");
    do_res(1, 12'h050, 5'd1, 1, 0, "R4 injected enabled");
    do_res(0, 12'h0, 5'd0, 0, 1, "R7 clear");

    // R5: single channel mode on channel 5, both groups
    do_cfg(1, 1, 1, 5'd5, 16'h0800, 16'h0100, 1, "R10 cfg single ch5");
    do_res(1, 12'hFFF, 5'd4, 0, 0, "R5 other channel ignored");
    do_res(1, 12'hFFF, 5'd4, 1, 0, "R5 other channel injected ignored");
    do_res(1, 12'hFFF, 5'd5, 0, 0, "R5 watched channel regular");
    do_res(0, 12'h0, 5'd0, 0, 1, "R7 clear");
    do_res(1, 12'h000, 5'd5, 1, 0, "R5 watched channel injected");
    do_res(0, 12'h0, 5'd0, 0, 1, "R7 clear");
    do_cfg(1, 1, 0, 5'd5, 16'h0800, 16'h0100, 0, "R10 cfg all channels");
    do_res(1, 12'hFFF, 5'd9, 0, 0, "R5 all channels mode");
    do_res(0, 12'h0, 5'd0, 0, 1, "R7 clear");

    // R6: illegal channel select stores zero; limit itself is legal
    do_cfg(1, 1, 1, 5'd20, 16'h0800, 16'h0100, 1, "R10 cfg ch20");
    do_res(1, 12'hFFF, 5'd20, 0, 0, "R6 channel 20 not watched");
    do_res(1, 12'hFFF, 5'd0, 0, 0, "R6 collapsed to channel 0");
    do_res(0, 12'h0, 5'd0, 0, 1, "R7 clear");
    do_cfg(1, 1, 1, 5'd17, 16'h0800, 16'h0100, 1, "R10 cfg ch17");
    do_res(1, 12'hFFF, 5'd0, 0, 0, "R6 channel 0 not watched");
    do_res(1, 12'hFFF, 5'd17, 1, 0, "R6 limit channel kept");
    do_res(0, 12'h0, 5'd0, 0, 0, "R8 idle");

    while (sb.size() > 0) @(posedge clk);
    repeat (2) @(posedge clk);
    finish_run();
  end

endmodule